// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Window

This block lets a host reach a private bank of memory-controller configuration registers through two host-visible words: an index word and a data word. The host first writes the index word, naming one internal register in its low seven bits and setting a write-intent flag in bit 8 when the next data access should store a value. It then reads or writes the data word. At the end of each access sequence, software writes 0x7F to the index word. This parks the window on an index that selects no storage.

The internal bank holds three groups of registers. The first is a page-translation control register, whose bit 0 drives the translation enable output. The second is the physical base address of the translation table, which is driven out as a 32-bit bus. The third is a flush control register, where a 0-to-1 write raises a one-clock request to invalidate the translation cache. Three further configuration registers hold values that software reads, modifies and writes back. They reset to their usual operating values.

The host port is a plain single-cycle request interface. It never applies back-pressure, so every request is accepted on the clock edge where it is presented. Read data arrives with a one-cycle valid flag on the cycle after the request.

Top module: `mcw_window`

## Requirements
- R1: After reset, `xlat_en` is 0, `xlat_table_base` is 0, `xlat_flush` is 0, and a read of the index word (offset 0x168) returns 0x0000007F.
- R2: A write to offset 0x168 stores bit 8 (the write flag) and bits [6:0] (the index). A read of 0x168 returns them in the same positions, with every other bit zero.
- R3: A data write (offset 0x16C) stores to the selected register only when the stored flag bit 8 is 1. When the flag is 0, the data write changes nothing.
- R4: A read request drives `host_rvalid` high for exactly the next cycle, with `host_rdata` valid in that cycle. A data read returns the selected register regardless of the flag.
- R5: Index 0x38 is a 32-bit control register that reads back as written. `xlat_en` equals its bit 0 from the cycle after the write.
- R6: Index 0x2C holds the 32-bit table base. It reads back as written and drives `xlat_table_base` from the cycle after the write.
- R7: Index 0x2E always reads as 0. A write whose bit 0 is 1, when the bit 0 last written there was 0, makes `xlat_flush` high for exactly the following cycle. Any other write to 0x2E raises no pulse.
- R8: Indices 0x18, 0x2B and 0x39 are read/write registers. Their reset values are 0x00001000, 0x42040800 and 0x01400000 respectively.
- R9: Every other index, including the park index 0x7F, reads as 0. Writes to these indices change no register and no output.
- R10: Host writes to offsets other than 0x168 and 0x16C have no effect, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | 12 | Byte offset of the host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid while host_rvalid is high |
| host_rvalid | output | 1 | High on the cycle after a read request |
| xlat_en | output | 1 | Page-translation enable (control bit 0) |
| xlat_table_base | output | 32 | Translation table physical base |
| xlat_flush | output | 1 | One-cycle translation-cache flush request |

## Verification
A wrong stored index or flag shows up on the very next data access. The access either reads back the wrong register or lets a write land where it should have been dropped. Read-back makes this visible one cycle after the read request. Corrupted control or base storage shows up on `xlat_en` or `xlat_table_base` one cycle after the offending write, with no read needed. A broken edge detector on the flush register shows up as a missing, doubled or spurious `xlat_flush` pulse in the cycle after the write. The sweep over all 128 indices, with flagged and unflagged writes, exposes a decode that aliases registers or lets unflagged writes through.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

  localparam int IDX_W  = 7;
  localparam int WORD_W = 32;

  localparam logic [IDX_W-1:0] IDX_CFG_A = 7'h18;
  localparam logic [IDX_W-1:0] IDX_CFG_B = 7'h2B;
  localparam logic [IDX_W-1:0] IDX_TBASE = 7'h2C;
  localparam logic [IDX_W-1:0] IDX_FLUSH = 7'h2E;
  localparam logic [IDX_W-1:0] IDX_GCTL  = 7'h38;
  localparam logic [IDX_W-1:0] IDX_CFG_C = 7'h39;
  localparam logic [IDX_W-1:0] IDX_PARK  = 7'h7F;

  localparam int N_OPQ = 3;

  // Index of the k-th opaque configuration register.
  function automatic logic [IDX_W-1:0] opq_idx(input int k);
    case (k)
      0:       opq_idx = IDX_CFG_A;
      1:       opq_idx = IDX_CFG_B;
      default: opq_idx = IDX_CFG_C;
    endcase
  endfunction

  // Reset value of the k-th opaque configuration register.
  function automatic logic [WORD_W-1:0] opq_rst(input int k);
    case (k)
      0:       opq_rst = 32'h0000_1000;
      1:       opq_rst = 32'h4204_0800;
      default: opq_rst = 32'h0140_0000;
    endcase
  endfunction

  // Decoded write into the internal bank.
  typedef struct packed {
    logic              wr;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] wdata;
  } bank_cmd_t;

endpackage

// File: rtl/mcw_host_decode.sv
module mcw_host_decode
  import mcw_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          FLAG_BIT  = 8,
  parameter logic [11:0] INDEX_OFS = 12'h168,
  parameter logic [11:0] DATA_OFS  = 12'h16C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] host_wdata,
  output bank_cmd_t         cmd,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_flag,
  output logic              hit_index,
  output logic              hit_data
);

  logic [IDX_W-1:0] idx_q;
  logic             flag_q;
  logic             index_wr;

  assign hit_index = (host_addr == INDEX_OFS[ADDR_W-1:0]);
  assign hit_data  = (host_addr == DATA_OFS[ADDR_W-1:0]);
  assign index_wr  = host_req && host_we && hit_index;

  // Index word: the index field plus the write-intent flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= IDX_PARK;
      flag_q <= 1'b0;
    end else if (index_wr) begin
      idx_q  <= host_wdata[IDX_W-1:0];
      flag_q <= host_wdata[FLAG_BIT];
    end
  end

  assign cur_idx  = idx_q;
  assign cur_flag = flag_q;

  always_comb begin
    cmd.wr    = host_req && host_we && hit_data && flag_q;
    cmd.idx   = idx_q;
    cmd.wdata = host_wdata;
  end

  // R2: the stored index changes only on a host write to the index offset.
  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !index_wr |=> $stable(cur_idx) && $stable(cur_flag));

  // R3: no bank write can occur while the flag is clear.
  a_r3_flag_gates_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_flag |-> !cmd.wr);

endmodule

// File: rtl/mcw_flush_gen.sv
module mcw_flush_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic bit_in,
  output logic pulse
);

  logic level_q;
  logic pulse_q;

  // Flush is requested on a 0-to-1 write of the stored bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wr && bit_in && !level_q;
      if (wr) level_q <= bit_in;
    end
  end

  assign pulse = pulse_q;

  // R7: a flush request never lasts two cycles.
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R7: no pulse without a write to the flush register.
  a_r7_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !pulse);

endmodule

// File: rtl/mcw_cfg_bank.sv
module mcw_cfg_bank
  import mcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bank_cmd_t         cmd,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_val,
  output logic [WORD_W-1:0] gctl,
  output logic [WORD_W-1:0] tbase,
  output logic              flush_wr,
  output logic              flush_bit
);

  logic [WORD_W-1:0] gctl_q;
  logic [WORD_W-1:0] tbase_q;
  logic [WORD_W-1:0] opq_q [N_OPQ];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gctl_q  <= '0;
      tbase_q <= '0;
    end else if (cmd.wr) begin
      if (cmd.idx == IDX_GCTL)  gctl_q  <= cmd.wdata;
      if (cmd.idx == IDX_TBASE) tbase_q <= cmd.wdata;
    end
  end

  // Opaque read-modify-write configuration registers.
  for (genvar k = 0; k < N_OPQ; k++) begin : g_opq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        opq_q[k] <= opq_rst(k);
      else if (cmd.wr && cmd.idx == opq_idx(k))
        opq_q[k] <= cmd.wdata;
    end
  end

  assign flush_wr  = cmd.wr && (cmd.idx == IDX_FLUSH);
  assign flush_bit = cmd.wdata[0];

  // Read mux: the flush register and unused indices read as zero.
  always_comb begin
    rd_val = '0;
    if (rd_idx == IDX_GCTL)  rd_val = gctl_q;
    if (rd_idx == IDX_TBASE) rd_val = tbase_q;
    for (int k = 0; k < N_OPQ; k++)
      if (rd_idx == opq_idx(k)) rd_val = opq_q[k];
  end

  assign gctl  = gctl_q;
  assign tbase = tbase_q;

  // R5: the control register moves only on a write to its index.
  a_r5_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.wr && cmd.idx == IDX_GCTL) |=> $stable(gctl));

  // R6: the table base moves only on a write to its index.
  a_r6_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.wr && cmd.idx == IDX_TBASE) |=> $stable(tbase));

endmodule

// File: rtl/mcw_window.sv
module mcw_window
  import mcw_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          FLAG_BIT  = 8,
  parameter logic [11:0] INDEX_OFS = 12'h168,
  parameter logic [11:0] DATA_OFS  = 12'h16C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              xlat_en,
  output logic [31:0]       xlat_table_base,
  output logic              xlat_flush
);

  localparam int PAD_W = WORD_W - FLAG_BIT - 1;

  bank_cmd_t         cmd;
  logic [IDX_W-1:0]  cur_idx;
  logic              cur_flag;
  logic              hit_index;
  logic              hit_data;
  logic [WORD_W-1:0] bank_rd;
  logic [WORD_W-1:0] gctl;
  logic [WORD_W-1:0] tbase;
  logic              flush_wr;
  logic              flush_bit;
  logic [WORD_W-1:0] index_word;
  logic [WORD_W-1:0] rd_next;
  logic              rd_req;

  mcw_host_decode #(
    .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT),
    .INDEX_OFS(INDEX_OFS), .DATA_OFS(DATA_OFS)
  ) u_dec (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .cmd(cmd), .cur_idx(cur_idx), .cur_flag(cur_flag),
    .hit_index(hit_index), .hit_data(hit_data)
  );

  mcw_cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rd_idx(cur_idx),
    .rd_val(bank_rd), .gctl(gctl), .tbase(tbase),
    .flush_wr(flush_wr), .flush_bit(flush_bit)
  );

  mcw_flush_gen u_flush (
    .clk(clk), .rst_n(rst_n), .wr(flush_wr), .bit_in(flush_bit),
    .pulse(xlat_flush)
  );

  assign index_word = {{PAD_W{1'b0}}, cur_flag,
                       {(FLAG_BIT-IDX_W){1'b0}}, cur_idx};
  assign rd_req = host_req && !host_we;

  always_comb begin
    rd_next = '0;
    if (hit_index)     rd_next = index_word;
    else if (hit_data) rd_next = bank_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_req;
      if (rd_req) host_rdata <= rd_next;
    end
  end

  assign xlat_en         = gctl[0];
  assign xlat_table_base = tbase;

  // R4: every read request gets a valid flag on the next cycle.
  a_r4_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> host_rvalid);

  // R4: no valid flag without a read request.
  a_r4_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !host_rvalid);

  // R9: a data write while parked leaves every output alone.
  a_r9_park_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && hit_data && cur_idx == IDX_PARK)
      |=> $stable(xlat_en) && $stable(xlat_table_base) && !xlat_flush);

  // R10: writes to other offsets touch nothing.
  a_r10_other_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && !hit_index && !hit_data)
      |=> $stable(xlat_en) && $stable(xlat_table_base) && !xlat_flush);

endmodule

// File: tb/tb_mcw_window.sv
module tb_mcw_window;

  localparam logic [11:0] A_IDX = 12'h168;
  localparam logic [11:0] A_DAT = 12'h16C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_rvalid;
  logic        xlat_en;
  logic [31:0] xlat_table_base;
  logic        xlat_flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] mdl [128];

  always #2 clk = ~clk;

  mcw_window dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .xlat_en(xlat_en), .xlat_table_base(xlat_table_base),
    .xlat_flush(xlat_flush)
  );

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    chk("R4 rvalid high", {31'b0, host_rvalid}, 32'h1);
    d = host_rdata;
  endtask

  function automatic bit is_impl(input int i);
    return i == 'h18 || i == 'h2B || i == 'h39 || i == 'h2C || i == 'h38;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pat;
    for (int i = 0; i < 128; i++) mdl[i] = 32'h0;
    mdl['h18] = 32'h0000_1000;
    mdl['h2B] = 32'h4204_0800;
    mdl['h39] = 32'h0140_0000;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 xlat_en", {31'b0, xlat_en}, 32'h0);
    chk("R1 table base", xlat_table_base, 32'h0);
    chk("R1 flush", {31'b0, xlat_flush}, 32'h0);
    rst_n = 1'b1;
    host_rd(A_IDX, v);
    chk("R1 index reset", v, 32'h0000_007F);
    @(negedge clk);
    chk("R4 rvalid single", {31'b0, host_rvalid}, 32'h0);

    // R2: index word stores bit 8 and bits 6:0 only
    host_wr(A_IDX, 32'hFFFF_FFFF);
    host_rd(A_IDX, v);
    chk("R2 index mask", v, 32'h0000_017F);
    host_wr(A_IDX, 32'h0000_0055);
    host_rd(A_IDX, v);
    chk("R2 index readback", v, 32'h0000_0055);

    // Sweep all indices: reset/current value, flagged write, unflagged write.
    for (int i = 0; i < 128; i++) begin
      host_wr(A_IDX, i);
      host_rd(A_DAT, v);
      chk(is_impl(i) ? "R8 reset/readback" : "R9 unimplemented read", v, mdl[i]);
      pat = {i[7:0], ~i[7:0], 8'hC3, i[7:0]};
      host_wr(A_IDX, 32'h100 | i);
      host_wr(A_DAT, pat);
      if (is_impl(i)) mdl[i] = pat;
      chk("R7 no flush on even write", {31'b0, xlat_flush}, 32'h0);
      chk("R5 xlat_en tracks bit0", {31'b0, xlat_en}, {31'b0, mdl['h38][0]});
      chk("R6 base output", xlat_table_base, mdl['h2C]);
      host_wr(A_IDX, i);
      host_wr(A_DAT, ~pat);
      chk("R3 unflagged base", xlat_table_base, mdl['h2C]);
      host_rd(A_DAT, v);
      chk(is_impl(i) ? "R3 flagged write kept" : "R9 write ignored", v, mdl[i]);
      host_wr(A_IDX, 32'h7F);
    end

    // R5: enable on/off
    host_wr(A_IDX, 32'h138);
    host_wr(A_DAT, 32'h5);
    chk("R5 enable on", {31'b0, xlat_en}, 32'h1);
    host_rd(A_DAT, v);
    chk("R5 readback", v, 32'h5);
    host_wr(A_DAT, 32'h4);
    chk("R5 enable off", {31'b0, xlat_en}, 32'h0);

    // R6: table base
    host_wr(A_IDX, 32'h12C);
    host_wr(A_DAT, 32'h33B0_0000);
    chk("R6 base value", xlat_table_base, 32'h33B0_0000);

    // R7: flush edge detection
    host_wr(A_IDX, 32'h12E);
    host_wr(A_DAT, 32'h1);
    chk("R7 pulse on rise", {31'b0, xlat_flush}, 32'h1);
    @(negedge clk);
    chk("R7 pulse one cycle", {31'b0, xlat_flush}, 32'h0);
    host_wr(A_DAT, 32'h1);
    chk("R7 no pulse on repeat 1", {31'b0, xlat_flush}, 32'h0);
    host_wr(A_DAT, 32'h0);
    chk("R7 no pulse on 0", {31'b0, xlat_flush}, 32'h0);
    host_wr(A_DAT, 32'h1);
    chk("R7 second pulse", {31'b0, xlat_flush}, 32'h1);
    host_rd(A_DAT, v);
    chk("R7 reads zero", v, 32'h0);

    // R9: parked writes do nothing
    host_wr(A_IDX, 32'h17F);
    host_wr(A_DAT, 32'hFFFF_FFFF);
    chk("R9 park en", {31'b0, xlat_en}, 32'h0);
    chk("R9 park base", xlat_table_base, 32'h33B0_0000);
    chk("R9 park flush", {31'b0, xlat_flush}, 32'h0);

    // R10: other offsets
    host_wr(A_IDX, 32'h12C);
    host_wr(12'h170, 32'hDEAD_BEEF);
    host_wr(12'h16D, 32'hDEAD_BEEF);
    chk("R10 write elsewhere", xlat_table_base, 32'h33B0_0000);
    host_rd(12'h170, v);
    chk("R10 read elsewhere", v, 32'h0);
    host_rd(A_DAT, v);
    chk("R10 base intact", v, 32'h33B0_0000);

    finish_run();
  end

endmodule